// File: doc/BRIEF.md
# Periodic Interval Timer with Tick Accumulator

This block is a free-running periodic timer behind a small synchronous register bus. The master clock is divided by sixteen. Each divided tick advances a 20-bit counter. When the counter has reached the programmed period value, the next tick returns it to zero. That event is called a wrap. A wrap sets a sticky status flag and adds one to a 12-bit count of wraps since software last acknowledged. The count saturates at its maximum.

Software can read the counter and the wrap count in two ways. One register returns them and acknowledges: the same read clears the count and the status flag. The other register returns the same word and changes nothing. A level interrupt is raised while the status flag and the interrupt enable are both set.

Turning the timer off does not stop it at once. It keeps counting until the counter is back at zero, and only then halts. Software can therefore poll the counter for zero to know that the timer has stopped.

Top module: `pit_tick_timer`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: While running, the counter advances exactly once every 16 clock cycles. The first advance lands on the 16th rising edge after the edge that stores the enable.
- R3: On a tick where the counter is at or above the period value, the counter returns to zero, so one period spans period+1 ticks.
- R4: Each wrap sets the status flag (bit 0 of the status register at offset 0x4, other bits zero) and adds one to the wrap count.
- R5: The wrap count stops at 4095 and does not roll over.
- R6: A read of offset 0x8 returns the counter in bits [19:0] and the wrap count in bits [31:20]. The read data appears the cycle after the read strobe. The same read clears the count and the status flag. If a wrap falls on the edge of that read, the count becomes 1 and the flag stays set.
- R7: A read of offset 0xC returns the same word as offset 0x8 and leaves the count and the flag unchanged.
- R8: `irq` is high exactly while the status flag and the interrupt enable are both set. With the interrupt enable clear, the count and the flag still work.
- R9: When the enable is cleared, counting continues until the counter is back at zero. The final wrap is counted. Then the counter and the prescaler hold at zero until the timer is enabled again.
- R10: The mode register at offset 0x0 holds the period value in bits [19:0], the timer enable in bit 24 and the interrupt enable in bit 25. It reads back as written, with other bits zero. A new period written while running is used from the next tick on.
- R11: Reads of any other offset, including misaligned ones, return zero. Writes to any offset but 0x0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe; data returned next cycle |
| rd_data | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The main function is swept over periods 0 through 4. At each period, reads come at irregular spacings and alternate between the observing view and the acknowledging view. This separates a correct period length and prescale from an off-by-one in either. It also shows whether acknowledging reads clear state and observing reads do not. Reads are placed on exact edges to test three corner cases: the first advance after enable, a wrap on the same edge as an acknowledging read, and the count running far past saturation. A separate run clears the enable in mid-period and checks that the counter stops only at zero, stays stopped, and restarts with a fresh prescaler. Another separate run shortens the period while the timer is counting.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned OFS_MODE = 32'h0;
  localparam int unsigned OFS_STAT = 32'h4;
  localparam int unsigned OFS_ACK  = 32'h8;
  localparam int unsigned OFS_IMG  = 32'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_STAT,
    SEL_ACK,
    SEL_IMG
  } reg_sel_e;
endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          at_last;

  assign at_last = (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (!run)         pre_d = '0;
    else if (at_last) pre_d = '0;
    else              pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && at_last;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic [CNT_W-1:0]  piv,
  input  logic              ack,
  output logic [CNT_W-1:0]  cpiv,
  output logic [TICK_W-1:0] picnt,
  output logic              pits,
  output logic              run
);
  localparam logic [TICK_W-1:0] CNT_MAX = '1;
  localparam logic [TICK_W-1:0] CNT_ONE = TICK_W'(1);

  logic [CNT_W-1:0]  cpiv_q, cpiv_d;
  logic [TICK_W-1:0] picnt_q, picnt_d;
  logic              pits_q, pits_d;
  logic              wrap;

  assign run  = en || (cpiv_q != '0);
  assign wrap = tick && (cpiv_q >= piv);

  always_comb begin
    cpiv_d = cpiv_q;
    if (tick) begin
      if (wrap) cpiv_d = '0;
      else      cpiv_d = cpiv_q + 1'b1;
    end
  end

  always_comb begin
    picnt_d = picnt_q;
    if (ack) begin
      picnt_d = wrap ? CNT_ONE : '0;
    end else if (wrap && (picnt_q != CNT_MAX)) begin
      picnt_d = picnt_q + 1'b1;
    end
  end

  always_comb begin
    pits_d = pits_q;
    if (wrap)     pits_d = 1'b1;
    else if (ack) pits_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpiv_q  <= '0;
      picnt_q <= '0;
      pits_q  <= 1'b0;
    end else begin
      cpiv_q  <= cpiv_d;
      picnt_q <= picnt_d;
      pits_q  <= pits_d;
    end
  end

  assign cpiv  = cpiv_q;
  assign picnt = picnt_q;
  assign pits  = pits_q;
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cpiv,
  input  logic [TICK_W-1:0] picnt,
  input  logic              pits,
  output logic [CNT_W-1:0]  piv,
  output logic              en,
  output logic              ien,
  output logic              ack
);
  localparam int EN_BIT  = CNT_W + 4;
  localparam int IEN_BIT = CNT_W + 5;

  reg_sel_e          sel;
  logic              mode_wr;
  logic [CNT_W-1:0]  piv_q, piv_d;
  logic              en_q, en_d;
  logic              ien_q, ien_d;
  logic [DATA_W-1:0] val_word;
  logic [DATA_W-1:0] mode_word;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              unused_wdata;

  assign unused_wdata = ^{wr_data[DATA_W-1:IEN_BIT+1], wr_data[EN_BIT-1:CNT_W]};

  always_comb begin
    if      (addr == ADDR_W'(OFS_MODE)) sel = SEL_MODE;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_ACK))  sel = SEL_ACK;
    else if (addr == ADDR_W'(OFS_IMG))  sel = SEL_IMG;
    else                                sel = SEL_NONE;
  end

  assign mode_wr = wr_en && (sel == SEL_MODE);
  assign ack     = rd_en && (sel == SEL_ACK);

  always_comb begin
    piv_d = piv_q;
    en_d  = en_q;
    ien_d = ien_q;
    if (mode_wr) begin
      piv_d = wr_data[CNT_W-1:0];
      en_d  = wr_data[EN_BIT];
      ien_d = wr_data[IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      piv_q <= '0;
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      piv_q <= piv_d;
      en_q  <= en_d;
      ien_q <= ien_d;
    end
  end

  always_comb begin
    val_word = '0;
    val_word[CNT_W-1:0]           = cpiv;
    val_word[DATA_W-1 -: TICK_W]  = picnt;
    mode_word = '0;
    mode_word[CNT_W-1:0] = piv_q;
    mode_word[EN_BIT]    = en_q;
    mode_word[IEN_BIT]   = ien_q;
  end

  always_comb begin
    unique case (sel)
      SEL_MODE: rd_mux = mode_word;
      SEL_STAT: rd_mux = {{(DATA_W-1){1'b0}}, pits};
      SEL_ACK,
      SEL_IMG:  rd_mux = val_word;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign piv     = piv_q;
  assign en      = en_q;
  assign ien     = ien_q;
endmodule

// File: rtl/pit_tick_timer.sv
module pit_tick_timer #(
  parameter int DIV    = 16,
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic              rst_sync_n;
  logic              tick;
  logic              run;
  logic [CNT_W-1:0]  cpiv;
  logic [TICK_W-1:0] picnt;
  logic              pits;
  logic [CNT_W-1:0]  piv;
  logic              mode_en;
  logic              mode_ien;
  logic              ack;

  pit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pit_prescale #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  pit_count_core #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .en    (mode_en),
    .piv   (piv),
    .ack   (ack),
    .cpiv  (cpiv),
    .picnt (picnt),
    .pits  (pits),
    .run   (run)
  );

  pit_regs #(
    .CNT_W(CNT_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .cpiv    (cpiv),
    .picnt   (picnt),
    .pits    (pits),
    .piv     (piv),
    .en      (mode_en),
    .ien     (mode_ien),
    .ack     (ack)
  );

  assign irq = pits && mode_ien;
endmodule

// File: rtl/pit_tick_timer_chk.sv
module pit_tick_timer_chk #(
  parameter int DIV    = 16,
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  cpiv,
  input logic [CNT_W-1:0]  piv,
  input logic [TICK_W-1:0] picnt,
  input logic              pits,
  input logic              en,
  input logic              ien,
  input logic              ack,
  input logic              irq
);
  localparam logic [TICK_W-1:0] CNT_MAX = '1;

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate

  AST_CPIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cpiv)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cpiv >= piv)) |=> (cpiv == '0)); // R3

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pits) |-> $past(tick)); // R4

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((picnt == CNT_MAX) && !ack) |=> (picnt == CNT_MAX)); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick) |=> ((picnt == '0) && !pits)); // R6

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R8

  AST_HALT_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && (cpiv == '0) && !ack) |=> ((cpiv == '0) && $stable(picnt))); // R9
endmodule

bind pit_tick_timer pit_tick_timer_chk #(
  .DIV(DIV), .CNT_W(CNT_W), .TICK_W(TICK_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .tick  (tick),
  .cpiv  (cpiv),
  .piv   (piv),
  .picnt (picnt),
  .pits  (pits),
  .en    (mode_en),
  .ien   (mode_ien),
  .ack   (ack),
  .irq   (irq)
);

// File: tb/tb_pit_tick_timer.sv
module tb_pit_tick_timer;
  localparam int DIV = 16, CNT_W = 20, TICK_W = 12, ADDR_W = 8, DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  pit_tick_timer #(.DIV(DIV), .CNT_W(CNT_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint e0, a0;
  longint pm;
  bit     ien_b;
  int     n_chk = 0, n_err = 0;

  function automatic longint tk(longint x);
    if (x < e0) return 0;
    return (x - e0) / DIV;
  endfunction
  function automatic longint wcnt(longint x);
    return tk(x) / pm;
  endfunction
  function automatic longint epicnt(longint x);
    longint v = wcnt(x) - wcnt(a0 - 1);
    return (v > 4095) ? 4095 : v;
  endfunction
  function automatic longint ecpiv(longint x);
    return tk(x) % pm;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output longint edge_n);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; edge_n = cyc;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output longint edge_n);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data; edge_n = cyc;
  endtask

  task automatic rd_at(input logic [ADDR_W-1:0] a, input longint target,
                       output logic [DATA_W-1:0] d, output longint edge_n);
    @(negedge clk);
    while (cyc < target - 1) @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data; edge_n = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    idle(3); rst_n = 1'b1; idle(4);
    e0 = 64'h3fff_ffff_ffff; a0 = e0; pm = 1;
  endtask

  task automatic enable(input int p, input bit ie);
    longint e;
    bus_wr(8'h00, (DATA_W'(ie) << 25) | (32'h1 << 24) | DATA_W'(p), e);
    e0 = e; a0 = e; pm = p + 1; ien_b = ie;
  endtask

  task automatic chk_val(input string req, input logic [DATA_W-1:0] d, input longint r);
    chk(req, "counter field", d[19:0], ecpiv(r - 1));
    chk(req, "wrap count field", d[31:20], epicnt(r - 1));
  endtask

  initial begin : main
    logic [DATA_W-1:0] d;
    longint r, dd, fin, tdis;
    ien_b = 1'b0;

    // Sweep over small periods
    for (int p = 0; p < 5; p++) begin
      do_reset();
      bus_rd(8'h00, d, r); chk("R1", "mode after reset", d, 0);
      bus_rd(8'h04, d, r); chk("R1", "status after reset", d, 0);
      bus_rd(8'h0C, d, r); chk("R1", "image after reset", d, 0);
      bus_rd(8'h08, d, r); chk("R1", "ack view after reset", d, 0);
      chk("R1", "irq after reset", irq, 0);
      enable(p, p[0]);
      bus_rd(8'h00, d, r);
      chk("R10", "mode readback", d, (longint'(p[0]) << 25) | (64'h1 << 24) | p);
      for (int k = 0; k < 8; k++) begin
        idle(7 + 11 * k + 5 * p);
        if (k % 2 == 1) begin
          bus_rd(8'h08, d, r); chk_val("R6", d, r); a0 = r;
        end else begin
          bus_rd(8'h0C, d, r); chk_val("R7", d, r);
        end
        bus_rd(8'h04, d, r);
        chk("R4", "status word", d, (epicnt(r - 1) > 0) ? 1 : 0);
        chk("R8", "irq level", irq, (ien_b && epicnt(cyc) > 0) ? 1 : 0);
      end
    end

    // R2 first advance and R10 period change while running
    do_reset();
    enable(7, 1'b0);
    rd_at(8'h0C, e0 + 16, d, r); chk("R2", "counter before first advance", d[19:0], 0);
    rd_at(8'h0C, e0 + 17, d, r); chk("R2", "counter after first advance", d[19:0], 1);
    @(negedge clk); while (cyc < e0 + 33) @(negedge clk);
    bus_wr(8'h00, (32'h1 << 24) | 32'd3, dd);
    chk("R10", "ticks at period change", tk(dd), 2);
    pm = 4;
    for (int k = 0; k < 5; k++) begin
      idle(9 + 17 * k);
      bus_rd(8'h0C, d, r); chk_val("R10", d, r);
    end
    bus_rd(8'h00, d, r); chk("R10", "mode after change", d, (64'h1 << 24) | 3);
    // R11 unmapped reads and ignored writes
    bus_rd(8'h10, d, r); chk("R11", "read 0x10", d, 0);
    bus_rd(8'h02, d, r); chk("R11", "read 0x02", d, 0);
    bus_wr(8'h04, '1, dd);
    bus_wr(8'h08, '1, dd);
    bus_wr(8'h0C, '1, dd);
    bus_wr(8'h02, '1, dd);
    bus_rd(8'h00, d, r); chk("R11", "mode after stray writes", d, (64'h1 << 24) | 3);
    bus_rd(8'h0C, d, r); chk_val("R11", d, r);

    // R6 wrap on the edge of the acknowledging read, R5 saturation
    do_reset();
    enable(0, 1'b1);
    rd_at(8'h08, e0 + 80, d, r);
    chk("R6", "count returned at coincident wrap", d[31:20], 4);
    a0 = r;
    bus_rd(8'h0C, d, r);
    chk("R6", "count after coincident wrap", d[31:20], 1);
    chk("R6", "irq after coincident wrap", irq, 1);
    rd_at(8'h0C, e0 + 16 * 4200 + 3, d, r);
    chk("R5", "saturated count", d[31:20], 4095);
    bus_rd(8'h08, d, r);
    chk("R5", "saturated count on ack", d[31:20], 4095);
    a0 = r;
    idle(40);
    bus_rd(8'h0C, d, r); chk_val("R5", d, r);

    // R9 disable mid period
    do_reset();
    enable(7, 1'b1);
    @(negedge clk); while (cyc < e0 + 16 * 19 + 4) @(negedge clk);
    bus_wr(8'h00, 32'd7, dd);
    tdis = tk(dd);
    chk("R9", "counter nonzero at disable", ((tdis % 8) != 0) ? 1 : 0, 1);
    fin = ((tdis + pm - 1) / pm) * pm;
    @(negedge clk); while (cyc < e0 + fin * DIV + 40) @(negedge clk);
    bus_rd(8'h0C, d, r);
    chk("R9", "counter after halt", d[19:0], 0);
    chk("R9", "final wrap counted", d[31:20], fin / pm);
    idle(300);
    bus_rd(8'h0C, d, r);
    chk("R9", "counter stays halted", d[19:0], 0);
    chk("R9", "count stays after halt", d[31:20], fin / pm);
    bus_rd(8'h08, d, r);
    enable(7, 1'b1);
    rd_at(8'h0C, e0 + 16 * 3 + 8, d, r); chk_val("R9", d, r);
    rd_at(8'h0C, e0 + 16 * 11 + 1, d, r); chk_val("R9", d, r);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule